// File: doc/BRIEF.md
# Packet Command Decoder with Sense Block

This block sits behind a storage-device bus protocol engine. The engine collects a 12-byte command packet and presents it with a one-cycle strobe. The decoder chooses one of three outcomes for the packet. It can start a data-in phase, start a data-out phase, or finish the command at once. For each outcome it sets the status, error and count registers that the host reads, and it pulses an interrupt request when the host must look at them.

The decoder holds two structures. The first is a 10-byte sense block that describes the last result. The second is a 32-byte mode page. For a data-in command it copies the requested bytes into the engine's transfer buffer, one byte per cycle. It then asks for a read transfer of that length. Multi-sector reads go to the media side through a request/response port. The decoder keeps the current block address and the remaining sector count, and it issues one request per sector.

After reset, the first packet that is not a sense request is refused with a unit-attention result. This forces the host to collect sense data before it can do anything else.

Top module: `pkt_cmd_decoder`

## Requirements
- R1: After reset, status_reg is 0x00, error_reg is 0x01, count_reg is 0x01, and irq, rd_start, wr_start, buf_we and sect_req are all low.
- R2: Every result code writes three places in the sense block: byte 0 becomes 0xF0, byte 2 the code's low byte, and byte 8 the code's high byte. It also sets error_reg to the code's low nibble shifted into bits 7:4, and count_reg to 3. A non-zero code sets status 0x51 and pulses irq. A zero code only clears status bits 7 and 0. The codes are: OK 0x0000, unit attention 0x2906, no media 0x3A02, bad opcode 0x2005, bad field 0x2405. A failed sector read uses the code that the media returns.
- R3: After reset, the first packet whose opcode (byte 0) is not 0x13 completes at once with the unit-attention code and clears the condition. A 0x13 packet is served normally and leaves the condition pending.
- R4: Opcode 0x13 (sense request) copies min(byte4, 10) sense bytes to buffer addresses 0 upward, taken as they were before the command. It then pulses rd_start with that length, sets status 0x58 and count 2, and writes the OK result.
- R5: Opcode 0x11 (mode read) uses byte 2 as the offset and byte 4 as the length. An offset of 32 or more gives bad field. Otherwise it copies min(len, 32 - offset) page bytes, starting at the offset, in the same way as R4. After reset, page byte i holds the value i.
- R6: Opcode 0x12 (mode write) makes the same offset check and applies the same length clip, writes OK, and pulses wr_start with the clipped length, with status 0x58 and count 0. Each received byte k goes to page position offset+k only when that position is below 10. After the last byte, status is 0x50, count is 3 and irq pulses. A clipped length of 0 completes at once with status 0x50.
- R7: Opcode 0x30 (sector read) takes a 24-bit start address from bytes 2..4 (most significant byte first), a 24-bit count from bytes 8..10 and the mode from byte 1, and writes OK. While sectors remain, it raises sect_req with the current address and mode. An ack with zero status advances the address by one, lowers the count by one, and pulses rd_start with sect_size, with status 0x58 and count 2. Each rd_done then gives status 0x50, count 3 and an irq pulse. A count of 0 completes at once with status 0x50.
- R8: A sector ack with non-zero status writes that status as the result. It stores the failing address in sense bytes 5, 6 and 7, most significant byte first, and stops the read.
- R9: With media_present low, opcodes 0x00 (ready test) and 0x30 give the no-media result. An unknown opcode gives bad opcode. Opcode 0x00 with media present completes with status 0x50, error 0 and an irq pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | Command packet strobe; accepted only while idle |
| pkt_data | input | 96 | Packet; byte k at bits 8k+7:8k |
| media_present | input | 1 | Media is loaded |
| buf_we | output | 1 | Transfer buffer write enable |
| buf_addr | output | LEN_W | Transfer buffer byte address |
| buf_wdata | output | 8 | Transfer buffer write data |
| rd_start | output | 1 | Start data-in transfer (pulse) |
| wr_start | output | 1 | Start data-out transfer (pulse) |
| xfer_len | output | LEN_W | Transfer length in bytes |
| rd_done | input | 1 | Data-in transfer finished |
| rx_valid | input | 1 | Data-out byte valid |
| rx_data | input | 8 | Data-out byte |
| sect_req | output | 1 | Sector read request |
| sect_lba | output | 24 | Requested block address |
| sect_mode | output | 8 | Requested read mode |
| sect_ack | input | 1 | Sector response valid |
| sect_status | input | 16 | Sector result code, 0 for success |
| sect_size | input | LEN_W | Bytes in the returned sector |
| status_reg | output | 8 | Host status register |
| error_reg | output | 8 | Host error register |
| count_reg | output | 8 | Host count/reason register |
| irq | output | 1 | Interrupt request pulse |

## Verification
Each kind of wrong internal state shows up at the ports in its own way.

- A wrong sector counter or block address appears on the next sect_req, one cycle after rd_done. A stale counter also shows as a request that should not be there, or a missing one.
- A bad clip or a bad offset shows as the wrong number of buffer writes, or the wrong byte values, before rd_start. Sweeping offsets and lengths across the page boundary and the write limit at byte 10 exposes both.
- A sense or mode-page byte that is held incorrectly stays hidden until the next sense or mode read. For that reason every result is followed by a read-back.

// File: rtl/pkt_cmd_decoder.sv
`timescale 1ns/1ps
module pkt_cmd_decoder #(
  parameter int SENSE_LEN = 10,
  parameter int PAGE_LEN  = 32,
  parameter int SEL_LIMIT = 10,
  parameter int LEN_W     = 12,
  parameter logic [23:0] RESET_LBA  = 24'd150,
  parameter logic [7:0]  RESET_MODE = 8'h28
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [95:0]      pkt_data,
  input  logic             media_present,
  output logic             buf_we,
  output logic [LEN_W-1:0] buf_addr,
  output logic [7:0]       buf_wdata,
  output logic             rd_start,
  output logic             wr_start,
  output logic [LEN_W-1:0] xfer_len,
  input  logic             rd_done,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             sect_req,
  output logic [23:0]      sect_lba,
  output logic [7:0]       sect_mode,
  input  logic             sect_ack,
  input  logic [15:0]      sect_status,
  input  logic [LEN_W-1:0] sect_size,
  output logic [7:0]       status_reg,
  output logic [7:0]       error_reg,
  output logic [7:0]       count_reg,
  output logic             irq
);
  localparam int PIW = $clog2(PAGE_LEN);
  localparam int SIW = $clog2(SENSE_LEN);
  localparam logic [8:0] P9 = 9'(PAGE_LEN);
  localparam logic [8:0] S9 = 9'(SENSE_LEN);
  localparam logic [8:0] L9 = 9'(SEL_LIMIT);
  localparam logic [7:0] OP_READY = 8'h00, OP_SENSE = 8'h13, OP_MREAD = 8'h11,
                         OP_MWRITE = 8'h12, OP_SREAD = 8'h30;
  localparam logic [15:0] RC_OK = 16'h0000, RC_UNIT = 16'h2906, RC_NOMEDIA = 16'h3A02,
                          RC_BADOP = 16'h2005, RC_BADFIELD = 16'h2405;

  typedef enum logic [2:0] {S_IDLE, S_COPY, S_DIN, S_DOUT, S_SREQ, S_SDIN} st_t;
  typedef enum logic [2:0] {A_NONE, A_DONE, A_COPY, A_DOUT, A_READ} act_t;

  st_t        st;
  act_t       act;
  logic [7:0] sense [SENSE_LEN];
  logic [7:0] page  [PAGE_LEN];
  logic       ua, src_page;
  logic [7:0] last_op, mode;
  logic [23:0] lba, scnt;
  logic [8:0] c_off, c_len, c_idx, d_off, d_len, d_idx;
  logic       res_we, fail_we;
  logic [15:0] res_code;

  wire [7:0] op = pkt_data[7:0];
  wire [7:0] b1 = pkt_data[15:8];
  wire [7:0] b2 = pkt_data[23:16];
  wire [7:0] b3 = pkt_data[31:24];
  wire [7:0] b4 = pkt_data[39:32];
  wire [23:0] blocks = pkt_data[87:64];
  logic unused_pkt;
  assign unused_pkt = ^{pkt_data[95:88], pkt_data[63:40]};

  wire       accept  = pkt_valid && (st == S_IDLE);
  wire       off_bad = {1'b0, b2} >= P9;
  wire [8:0] room    = P9 - {1'b0, b2};
  wire [8:0] m_len   = ({1'b0, b4} > room) ? room : {1'b0, b4};
  wire [8:0] s_len   = ({1'b0, b4} > S9) ? S9 : {1'b0, b4};
  wire       copy_end = (st == S_COPY) && (c_idx == c_len);
  wire [8:0] rd_pos  = c_off + c_idx;
  wire [8:0] wr_pos  = d_off + d_idx;
  wire       sect_bad = (st == S_SREQ) && sect_ack && (sect_status != RC_OK);

  assign buf_we    = (st == S_COPY) && (c_idx != c_len);
  assign buf_addr  = LEN_W'(c_idx);
  assign buf_wdata = src_page ? page[rd_pos[PIW-1:0]] : sense[c_idx[SIW-1:0]];
  assign sect_req  = (st == S_SREQ);
  assign sect_lba  = lba;
  assign sect_mode = mode;

  always_comb begin
    act = A_NONE; res_we = 1'b0; res_code = RC_OK; fail_we = 1'b0;
    if (accept) begin
      if (ua && op != OP_SENSE) begin
        res_we = 1'b1; res_code = RC_UNIT;
      end else begin
        case (op)
          OP_READY:
            if (!media_present) begin res_we = 1'b1; res_code = RC_NOMEDIA; end
            else begin res_we = 1'b1; act = A_DONE; end
          OP_SENSE: act = A_COPY;
          OP_MREAD:
            if (off_bad) begin res_we = 1'b1; res_code = RC_BADFIELD; end
            else act = A_COPY;
          OP_MWRITE:
            if (off_bad) begin res_we = 1'b1; res_code = RC_BADFIELD; end
            else begin res_we = 1'b1; act = (m_len == 9'd0) ? A_DONE : A_DOUT; end
          OP_SREAD:
            if (!media_present) begin res_we = 1'b1; res_code = RC_NOMEDIA; end
            else begin res_we = 1'b1; act = (blocks == 24'd0) ? A_DONE : A_READ; end
          default: begin res_we = 1'b1; res_code = RC_BADOP; end
        endcase
      end
    end else if (copy_end) begin
      res_we = 1'b1;
    end else if (sect_bad) begin
      res_we = 1'b1; res_code = sect_status; fail_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SENSE_LEN; i++) sense[i] <= 8'h00;
    end else begin
      if (res_we) begin
        sense[0] <= 8'hF0;
        sense[2] <= res_code[7:0];
        sense[8] <= res_code[15:8];
      end
      if (fail_we) begin
        sense[5] <= lba[23:16];
        sense[6] <= lba[15:8];
        sense[7] <= lba[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; status_reg <= 8'h00; error_reg <= 8'h01; count_reg <= 8'h01;
      irq <= 1'b0; rd_start <= 1'b0; wr_start <= 1'b0; xfer_len <= '0;
      ua <= 1'b1; last_op <= 8'h00; lba <= RESET_LBA; scnt <= 24'd0; mode <= RESET_MODE;
      src_page <= 1'b0; c_off <= '0; c_len <= '0; c_idx <= '0;
      d_off <= '0; d_len <= '0; d_idx <= '0;
      for (int i = 0; i < PAGE_LEN; i++) page[i] <= 8'(i);
    end else begin
      irq <= 1'b0; rd_start <= 1'b0; wr_start <= 1'b0;
      if (res_we) begin
        error_reg <= {res_code[3:0], 4'h0};
        count_reg <= 8'd3;
        if (res_code != RC_OK) begin status_reg <= 8'h51; irq <= 1'b1; end
        else status_reg <= status_reg & 8'h7E;
      end
      if (accept && ua && op != OP_SENSE) ua <= 1'b0;
      if (act != A_NONE) last_op <= op;
      case (act)
        A_DONE: begin status_reg <= 8'h50; count_reg <= 8'd3; irq <= 1'b1; end
        A_COPY: begin
          st <= S_COPY; c_idx <= '0;
          src_page <= (op == OP_MREAD);
          c_off <= (op == OP_MREAD) ? {1'b0, b2} : 9'd0;
          c_len <= (op == OP_MREAD) ? m_len : s_len;
        end
        A_DOUT: begin
          st <= S_DOUT; d_idx <= '0; d_off <= {1'b0, b2}; d_len <= m_len;
          wr_start <= 1'b1; xfer_len <= LEN_W'(m_len);
          status_reg <= 8'h58; count_reg <= 8'd0;
        end
        A_READ: begin st <= S_SREQ; lba <= {b2, b3, b4}; scnt <= blocks; mode <= b1; end
        default: ;
      endcase
      case (st)
        S_COPY:
          if (copy_end) begin
            rd_start <= 1'b1; xfer_len <= LEN_W'(c_len);
            status_reg <= 8'h58; count_reg <= 8'd2; st <= S_DIN;
          end else c_idx <= c_idx + 9'd1;
        S_DIN:
          if (rd_done) begin
            status_reg <= 8'h50; count_reg <= 8'd3; irq <= 1'b1; st <= S_IDLE;
          end
        S_DOUT:
          if (rx_valid) begin
            if (last_op == OP_MWRITE && wr_pos < L9) page[wr_pos[PIW-1:0]] <= rx_data;
            d_idx <= d_idx + 9'd1;
            if (d_idx + 9'd1 == d_len) begin
              status_reg <= 8'h50; count_reg <= 8'd3; irq <= 1'b1; st <= S_IDLE;
            end
          end
        S_SREQ:
          if (sect_ack) begin
            if (sect_status == RC_OK) begin
              lba <= lba + 24'd1; scnt <= scnt - 24'd1;
              rd_start <= 1'b1; xfer_len <= sect_size;
              status_reg <= 8'h58; count_reg <= 8'd2; st <= S_SDIN;
            end else st <= S_IDLE;
          end
        S_SDIN:
          if (rd_done) begin
            status_reg <= 8'h50; count_reg <= 8'd3; irq <= 1'b1;
            st <= (scnt != 24'd0) ? S_SREQ : S_IDLE;
          end
        default: ;
      endcase
    end
  end

  assert_start_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_start && wr_start));
  assert_sense_clip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !src_page) |-> (c_idx < S9));
  assert_page_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && src_page) |-> (rd_pos < P9));
  assert_sector_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SREQ) && sect_ack && (sect_status == RC_OK)) |=>
      ((scnt == $past(scnt) - 24'd1) && (lba == $past(lba) + 24'd1)));
  assert_req_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sect_req |-> (scnt != 24'd0));
  assert_unit_att_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ua && op != OP_SENSE) |=> (status_reg == 8'h51 && irq && !ua));
  assert_fail_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sect_bad |=> (st == S_IDLE && status_reg == 8'h51 && irq));
endmodule

// File: tb/pkt_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module pkt_cmd_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_valid = 1'b0, media_present = 1'b1;
  logic [95:0] pkt_data = '0;
  logic buf_we, rd_start, wr_start, sect_req, irq;
  logic [11:0] buf_addr, xfer_len;
  logic [7:0] buf_wdata, sect_mode, status_reg, error_reg, count_reg;
  logic rd_done = 1'b0, rx_valid = 1'b0, sect_ack = 1'b0;
  logic [7:0] rx_data = '0;
  logic [15:0] sect_status = '0;
  logic [11:0] sect_size = '0;
  logic [23:0] sect_lba;

  always #2.5 clk = ~clk;

  pkt_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .media_present(media_present), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .rd_start(rd_start), .wr_start(wr_start),
    .xfer_len(xfer_len), .rd_done(rd_done), .rx_valid(rx_valid), .rx_data(rx_data),
    .sect_req(sect_req), .sect_lba(sect_lba), .sect_mode(sect_mode),
    .sect_ack(sect_ack), .sect_status(sect_status), .sect_size(sect_size),
    .status_reg(status_reg), .error_reg(error_reg), .count_reg(count_reg), .irq(irq));

  int errors = 0, checks = 0, ncap = 0, nirq = 0, seen_len = 0;
  logic seen_rd = 1'b0, seen_wr = 1'b0, done = 1'b0;
  logic [7:0] cap [64];
  logic [7:0] exp_sense [10];
  logic [7:0] page_m [32];

  always @(negedge clk) begin
    if (buf_we) begin cap[buf_addr[5:0]] = buf_wdata; ncap++; end
    if (rd_start) begin seen_rd = 1'b1; seen_len = int'(xfer_len); end
    if (wr_start) begin seen_wr = 1'b1; seen_len = int'(xfer_len); end
    if (irq) nirq++;
  end

  task automatic chk(input string tag, input int got, input int expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, expv);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask
  task automatic clr(); ncap = 0; nirq = 0; seen_rd = 1'b0; seen_wr = 1'b0; endtask
  task automatic set_res(input int code);
    exp_sense[0] = 8'hF0; exp_sense[2] = code[7:0]; exp_sense[8] = code[15:8];
  endtask

  task automatic send(input logic [7:0] op, input logic [7:0] p1, input logic [7:0] p2,
                      input logic [7:0] p3, input logic [7:0] p4, input logic [23:0] blk);
    clr();
    pkt_data = '0;
    pkt_data[7:0] = op; pkt_data[15:8] = p1; pkt_data[23:16] = p2;
    pkt_data[31:24] = p3; pkt_data[39:32] = p4; pkt_data[87:64] = blk;
    pkt_valid = 1'b1; step(); pkt_valid = 1'b0;
  endtask

  task automatic wait_rd();
    for (int i = 0; i < 200 && !seen_rd; i++) step();
  endtask

  task automatic finish_din(input string tag);
    nirq = 0;
    rd_done = 1'b1; step(); rd_done = 1'b0;
    chk({tag, " end status"}, status_reg, 8'h50);
    chk({tag, " end count"}, count_reg, 3);
    chk({tag, " end irq"}, nirq, 1);
  endtask

  task automatic expect_fail(input string tag, input int code);
    chk({tag, " status"}, status_reg, 8'h51);
    chk({tag, " error"}, error_reg, (code & 15) << 4);
    chk({tag, " count"}, count_reg, 3);
    chk({tag, " irq"}, nirq, 1);
    set_res(code);
  endtask

  task automatic do_sense(input int alloc);
    int n;
    n = (alloc > 10) ? 10 : alloc;
    send(8'h13, 0, 0, 0, 8'(alloc), 0);
    wait_rd();
    chk("R4 rd_start seen", int'(seen_rd), 1);
    chk("R4 length", seen_len, n);
    chk("R4 byte count", ncap, n);
    for (int i = 0; i < n; i++) chk("R4 sense byte", cap[i], exp_sense[i]);
    chk("R4 status", status_reg, 8'h58);
    chk("R4 count", count_reg, 2);
    set_res(0);
    finish_din("R4");
  endtask

  task automatic do_mread(input int off, input int alloc);
    int n;
    send(8'h11, 0, 8'(off), 0, 8'(alloc), 0);
    if (off >= 32) begin
      expect_fail("R5 bad offset", 16'h2405);
      return;
    end
    n = (alloc > 32 - off) ? 32 - off : alloc;
    wait_rd();
    chk("R5 length", seen_len, n);
    chk("R5 byte count", ncap, n);
    for (int i = 0; i < n; i++) chk("R5 page byte", cap[i], page_m[off + i]);
    set_res(0);
    finish_din("R5");
  endtask

  task automatic do_mwrite(input int off, input int len, input int seed);
    int n;
    send(8'h12, 0, 8'(off), 0, 8'(len), 0);
    if (off >= 32) begin
      expect_fail("R6 bad offset", 16'h2405);
      return;
    end
    set_res(0);
    n = (len > 32 - off) ? 32 - off : len;
    if (n == 0) begin
      chk("R6 zero status", status_reg, 8'h50);
      chk("R6 zero irq", nirq, 1);
      chk("R6 zero count", count_reg, 3);
      return;
    end
    chk("R6 wr_start", int'(seen_wr), 1);
    chk("R6 length", seen_len, n);
    chk("R6 status", status_reg, 8'h58);
    chk("R6 count", count_reg, 0);
    for (int k = 0; k < n; k++) begin
      rx_valid = 1'b1; rx_data = 8'(seed + k); step();
      if (off + k < 10) page_m[off + k] = 8'(seed + k);
    end
    rx_valid = 1'b0;
    chk("R6 end status", status_reg, 8'h50);
    chk("R6 end count", count_reg, 3);
    chk("R6 end irq", nirq, 1);
  endtask

  task automatic do_sread(input int start, input int cnt, input int fail_at,
                          input int code, input logic [7:0] md, input int pre_status);
    int a;
    send(8'h30, md, start[23:16], start[15:8], start[7:0], cnt[23:0]);
    set_res(0);
    if (pre_status >= 0) chk("R2 zero result clears only bits 7,0", status_reg, pre_status);
    if (cnt == 0) begin
      chk("R7 zero count status", status_reg, 8'h50);
      chk("R7 zero count irq", nirq, 1);
      return;
    end
    for (int s = 0; s < cnt; s++) begin
      for (int i = 0; i < 50 && !sect_req; i++) step();
      a = (start + s) & 24'hFFFFFF;
      chk("R7 request", int'(sect_req), 1);
      chk("R7 address", int'(sect_lba), a);
      chk("R7 mode", sect_mode, md);
      clr();
      if (s == fail_at) begin
        sect_ack = 1'b1; sect_status = code[15:0]; step();
        sect_ack = 1'b0; sect_status = '0;
        expect_fail("R8 sector failure", code);
        exp_sense[5] = a[23:16]; exp_sense[6] = a[15:8]; exp_sense[7] = a[7:0];
        step(); step();
        chk("R8 read stopped", int'(sect_req), 0);
        return;
      end
      sect_ack = 1'b1; sect_size = 12'(16 + s); step(); sect_ack = 1'b0;
      chk("R7 rd_start", int'(seen_rd), 1);
      chk("R7 sector length", seen_len, 16 + s);
      chk("R7 status", status_reg, 8'h58);
      chk("R7 count", count_reg, 2);
      finish_din("R7");
    end
    step(); step(); step();
    chk("R7 no extra request", int'(sect_req), 0);
  endtask

  initial begin
    for (int i = 0; i < 10; i++) exp_sense[i] = 8'h00;
    for (int i = 0; i < 32; i++) page_m[i] = 8'(i);
    repeat (3) step();
    rst_n = 1'b1; step();
    chk("R1 status", status_reg, 8'h00);
    chk("R1 error", error_reg, 8'h01);
    chk("R1 count", count_reg, 8'h01);
    chk("R1 strobes", int'({irq, rd_start, wr_start, buf_we, sect_req}), 0);

    do_sense(12);
    send(8'h00, 0, 0, 0, 0, 0);
    expect_fail("R3 unit attention", 16'h2906);
    for (int a = 0; a <= 12; a++) do_sense(a);
    send(8'h00, 0, 0, 0, 0, 0);
    chk("R9 ready status", status_reg, 8'h50);
    chk("R9 ready error", error_reg, 0);
    chk("R9 ready irq", nirq, 1);
    set_res(0);

    media_present = 1'b0;
    send(8'h00, 0, 0, 0, 0, 0);
    expect_fail("R9 no media ready", 16'h3A02);
    send(8'h30, 0, 0, 0, 1, 24'd1);
    expect_fail("R9 no media read", 16'h3A02);
    do_sense(10);
    media_present = 1'b1;
    send(8'h5A, 0, 0, 0, 0, 0);
    expect_fail("R9 unknown opcode", 16'h2005);
    do_sense(10);

    for (int o = 0; o <= 33; o++) begin
      do_mread(o, 0); do_mread(o, 3); do_mread(o, 17); do_mread(o, 40);
    end
    do_sense(10);
    for (int o = 0; o <= 12; o++) begin
      do_mwrite(o, 0, 0); do_mwrite(o, 4, 8'h80 + 16 * o);
    end
    do_mwrite(30, 8, 8'hC0);
    do_mwrite(40, 2, 0);
    do_mread(0, 32);
    do_sense(10);

    do_sread(1000, 3, -1, 0, 8'h28, -1);
    do_sread(24'hFFFE, 4, 2, 16'h1103, 8'h24, -1);
    do_sense(10);
    send(8'h5A, 0, 0, 0, 0, 0);
    expect_fail("R2 failure before read", 16'h2005);
    do_sread(500, 1, -1, 0, 8'h20, 8'h50);
    do_sread(77, 0, -1, 0, 8'h20, -1);
    do_sense(10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule